// File: doc/BRIEF.md
# Balanced Seven-Lane Link Encoder and Gearbox

The block carries a 192-bit parallel word across a short die-to-die link made of seven single-ended NRZ lanes. The transmit side accepts a word over a valid/ready handshake. It views the word as six 32-bit groups and, over 32 consecutive cycles, builds one 6-bit symbol per cycle from the same bit position of every group. Each symbol is mapped to a 7-bit lane pattern holding three or four ones. Within any one cycle the lanes therefore switch close to half up and half down, and the return current behaves much as it would on a differential pair.

The receive side decodes each 7-bit lane pattern back to 6 bits and flags any pattern outside the codebook. It uses a start-of-word strobe, sent beside the first symbol, to align the 32 symbols and rebuild the 192-bit word. When both sides are tied back to back, each word comes out a fixed number of cycles after it was accepted. Words can follow each other with no idle cycle between them.

Top module: `bal_link_gearbox`

## Requirements
- R1: `tx_ready` is high while the transmitter is idle, and in the cycle in which the current word's last (32nd) symbol is being formed. A word is taken on a rising edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low in the cycle after a word is taken.
- R2: Symbol k (k = 0..31) has bit i equal to `tx_word[32*i+k]`. Symbol k appears on `tx_lanes` after the (k+2)-th rising edge, counting the accepting edge as the first. `tx_sow` is high only while symbol 0 is on the lanes.
- R3: Data value d is sent as the (d+1)-th smallest 7-bit value that has exactly three or four ones, so 0 maps to 7'b0000111 and 63 maps to 7'b1101010. Every value on `tx_lanes` has three or four ones.
- R4: With no word in flight, `tx_lanes` holds 7'b0000111 (the code of data 0) and `tx_sow` is low.
- R5: `rx_sym` and `rx_code_err` hold the decode of the `rx_lanes` value sampled at the previous edge. The six unused balanced values (7'b1101100, 7'b1110000, 7'b1110001, 7'b1110010, 7'b1110100, 7'b1111000) and every value with fewer than three or more than four ones set `rx_code_err` and give `rx_sym` = 0.
- R6: The symbol sampled while `rx_sow` is high is symbol 0 of a word. The edge that samples symbol 31 raises `rx_word_valid` for exactly one cycle, with `rx_word[32*i+k]` equal to bit i of symbol k. Without a strobe no word is produced. With the transmit outputs fed straight to the receive inputs, `rx_word_valid` rises 33 edges after the accepting edge.
- R7: A symbol that fails decoding contributes zeros to its 6 bit positions in the rebuilt word. The rest of the word is unaffected.
- R8: A strobe that arrives while a word is partly assembled discards the partial word and starts a new word at symbol 0.
- R9: A word presented while the previous one is in flight is accepted exactly 32 edges after the previous one, so lane symbols and rebuilt words follow with no gap.
- R10: During and right after reset: `tx_ready` = 1, `tx_sow` = 0, `tx_lanes` = 7'b0000111, `rx_word_valid` = 0, `rx_code_err` = 0 and `rx_sym` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_word | input | 192 | Transmit payload |
| tx_ready | output | 1 | Transmitter can take a word this cycle |
| tx_lanes | output | 7 | Balanced lane pattern driven to the link |
| tx_sow | output | 1 | Start-of-word strobe, beside symbol 0 |
| rx_lanes | input | 7 | Lane pattern received from the link |
| rx_sow | input | 1 | Received start-of-word strobe |
| rx_sym | output | 6 | Decoded symbol of the previous cycle |
| rx_code_err | output | 1 | Previous lane pattern was not a codeword |
| rx_word | output | 192 | Rebuilt payload, valid with rx_word_valid |
| rx_word_valid | output | 1 | One-cycle pulse when a word is complete |

## Verification
The encoder result is due one cycle after the edge that steps the transmit counter. The lane checks therefore read symbol k at the falling edge that follows the (k+2)-th edge after acceptance, and `tx_sow` is checked at that same point. A decoder result is due one edge after the lane value is driven, so the codebook sweep and the error-injection steps read `rx_sym` and `rx_code_err` at the next falling edge. Each accepted word goes into a scoreboard stamped with its accepting edge plus 33. Injected and restarted words are stamped 32 edges after their driven strobe. The monitor compares the rebuilt word, and the cycle in which `rx_word_valid` appears, against that stamp.

// File: rtl/bal_link_pkg.sv
package bal_link_pkg;
   localparam int SYM_BITS   = 6;
   localparam int CODE_BITS  = 7;
   localparam int NUM_SYMS   = 1 << SYM_BITS;
   localparam int NUM_PATS   = 1 << CODE_BITS;

   typedef logic [SYM_BITS-1:0]  sym_t;
   typedef logic [CODE_BITS-1:0] code_t;
   typedef code_t [NUM_SYMS-1:0] enc_tbl_t;
   typedef sym_t  [NUM_PATS-1:0] dec_tbl_t;
   typedef logic  [NUM_PATS-1:0] ok_tbl_t;

   function automatic int unsigned weight(input code_t c);
      int unsigned n = 0;
      for (int b = 0; b < CODE_BITS; b++) n += int'(c[b]);
      return n;
   endfunction

   function automatic logic is_balanced(input code_t c);
      return (weight(c) == 3) || (weight(c) == 4);
   endfunction

   // Symbol d takes the d-th balanced pattern in ascending order.
   function automatic enc_tbl_t build_enc();
      enc_tbl_t t = '0;
      int n = 0;
      for (int v = 0; v < NUM_PATS; v++) begin
         if (is_balanced(code_t'(v)) && n < NUM_SYMS) begin
            t[n] = code_t'(v);
            n++;
         end
      end
      return t;
   endfunction

   function automatic dec_tbl_t build_dec();
      dec_tbl_t t = '0;
      int n = 0;
      for (int v = 0; v < NUM_PATS; v++) begin
         if (is_balanced(code_t'(v)) && n < NUM_SYMS) begin
            t[v] = sym_t'(n);
            n++;
         end
      end
      return t;
   endfunction

   function automatic ok_tbl_t build_ok();
      ok_tbl_t t = '0;
      int n = 0;
      for (int v = 0; v < NUM_PATS; v++) begin
         if (is_balanced(code_t'(v)) && n < NUM_SYMS) begin
            t[v] = 1'b1;
            n++;
         end
      end
      return t;
   endfunction

   localparam enc_tbl_t ENC_TBL   = build_enc();
   localparam dec_tbl_t DEC_TBL   = build_dec();
   localparam ok_tbl_t  OK_TBL    = build_ok();
   localparam code_t    IDLE_CODE = ENC_TBL[0];
endpackage

// File: rtl/bal_sym_enc.sv
module bal_sym_enc
   import bal_link_pkg::*;
(
   input  sym_t  sym,
   output code_t code
);
   assign code = ENC_TBL[sym];
endmodule

// File: rtl/bal_sym_dec.sv
module bal_sym_dec
   import bal_link_pkg::*;
(
   input  code_t code,
   output sym_t  sym,
   output logic  bad
);
   // Table entries for unused patterns are zero.
   assign sym = DEC_TBL[code];
   assign bad = ~OK_TBL[code];
endmodule

// File: rtl/bal_tx_gearbox.sv
module bal_tx_gearbox #(
   parameter int GROUPS     = 6,
   parameter int GROUP_BITS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         word_valid,
   input  logic [GROUPS*GROUP_BITS-1:0] word,
   output logic                         word_ready,
   output logic [GROUPS-1:0]            sym,
   output logic                         sym_first
);
   localparam int CNT_W = $clog2(GROUP_BITS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_BITS - 1);

   logic             busy_q;
   logic [CNT_W-1:0] idx_q;
   logic             last_beat;
   logic             take;

   assign last_beat  = busy_q && (idx_q == LAST_IDX);
   assign word_ready = !busy_q || last_beat;
   assign take       = word_valid && word_ready;
   assign sym_first  = busy_q && (idx_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (last_beat) busy_q <= 1'b0;
         idx_q <= idx_q + CNT_W'(1);
      end
   end

   // One shifter per group; the group's LSB leaves first.
   for (genvar g = 0; g < GROUPS; g++) begin : g_slice
      logic [GROUP_BITS-1:0] shf_q;
      always_ff @(posedge clk) begin
         if (take)        shf_q <= word[g*GROUP_BITS +: GROUP_BITS];
         else if (busy_q) shf_q <= shf_q >> 1;
      end
      assign sym[g] = busy_q & shf_q[0];
   end
endmodule

// File: rtl/bal_rx_gearbox.sv
module bal_rx_gearbox #(
   parameter int GROUPS     = 6,
   parameter int GROUP_BITS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [GROUPS-1:0]            sym,
   input  logic                         sow,
   output logic [GROUPS*GROUP_BITS-1:0] word,
   output logic                         word_valid
);
   localparam int CNT_W = $clog2(GROUP_BITS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_BITS - 1);

   logic             act_q;
   logic [CNT_W-1:0] idx_q;
   logic             done_q;
   logic             shift;

   assign shift      = sow || act_q;
   assign word_valid = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (sow) begin
            act_q <= 1'b1;
            idx_q <= CNT_W'(1);
         end else if (act_q) begin
            idx_q <= idx_q + CNT_W'(1);
            if (idx_q == LAST_IDX) begin
               act_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // Bits enter at the MSB so that symbol 0 ends at bit 0.
   for (genvar g = 0; g < GROUPS; g++) begin : g_pack
      logic [GROUP_BITS-1:0] shf_q;
      always_ff @(posedge clk) begin
         if (shift) shf_q <= {sym[g], shf_q[GROUP_BITS-1:1]};
      end
      assign word[g*GROUP_BITS +: GROUP_BITS] = shf_q;
   end
endmodule

// File: rtl/bal_link_gearbox.sv
module bal_link_gearbox
   import bal_link_pkg::*;
#(
   parameter int GROUPS     = 6,
   parameter int GROUP_BITS = 32,
   parameter bit LANE_REG   = 1'b1,
   localparam int WORD_BITS = GROUPS * GROUP_BITS,
   localparam int LANES     = CODE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_valid,
   input  logic [WORD_BITS-1:0] tx_word,
   output logic                 tx_ready,
   output logic [LANES-1:0]     tx_lanes,
   output logic                 tx_sow,
   input  logic [LANES-1:0]     rx_lanes,
   input  logic                 rx_sow,
   output logic [GROUPS-1:0]    rx_sym,
   output logic                 rx_code_err,
   output logic [WORD_BITS-1:0] rx_word,
   output logic                 rx_word_valid
);
   if (GROUPS != SYM_BITS) begin : g_bad_groups
      $error("GROUPS must equal the codebook symbol width");
   end
   if (GROUP_BITS < 2 || (GROUP_BITS & (GROUP_BITS - 1)) != 0) begin : g_bad_depth
      $error("GROUP_BITS must be a power of two, at least 2");
   end

   sym_t  tx_sym;
   logic  tx_first;
   code_t tx_code;
   sym_t  dec_sym;
   logic  dec_bad;

   bal_tx_gearbox #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (tx_valid),
      .word       (tx_word),
      .word_ready (tx_ready),
      .sym        (tx_sym),
      .sym_first  (tx_first)
   );

   bal_sym_enc u_enc (.sym(tx_sym), .code(tx_code));

   if (LANE_REG) begin : g_lane_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tx_lanes <= IDLE_CODE;
            tx_sow   <= 1'b0;
         end else begin
            tx_lanes <= tx_code;
            tx_sow   <= tx_first;
         end
      end
   end else begin : g_lane_comb
      assign tx_lanes = tx_code;
      assign tx_sow   = tx_first;
   end

   bal_sym_dec u_dec (.code(rx_lanes), .sym(dec_sym), .bad(dec_bad));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_sym      <= '0;
         rx_code_err <= 1'b0;
      end else begin
         rx_sym      <= dec_sym;
         rx_code_err <= dec_bad;
      end
   end

   bal_rx_gearbox #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sym        (dec_sym),
      .sow        (rx_sow),
      .word       (rx_word),
      .word_valid (rx_word_valid)
   );
endmodule

// File: rtl/bal_link_chk.sv
module bal_link_chk #(
   parameter int LANES   = 7,
   parameter int SYMW    = 6,
   parameter int SOW_DLY = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [LANES-1:0] tx_lanes,
   input logic             tx_sow,
   input logic [SYMW-1:0]  rx_sym,
   input logic             rx_code_err,
   input logic             rx_word_valid
);
   assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   assert_sow_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |-> ##(SOW_DLY) tx_sow);

   assert_lane_balance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tx_lanes) == 3) || ($countones(tx_lanes) == 4));

   assert_err_zero_sym_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_code_err |-> (rx_sym == '0));

   assert_word_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_valid |=> !rx_word_valid);
endmodule

bind bal_link_gearbox bal_link_chk #(
   .LANES   (LANES),
   .SYMW    (GROUPS),
   .SOW_DLY (LANE_REG ? 2 : 1)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_valid      (tx_valid),
   .tx_ready      (tx_ready),
   .tx_lanes      (tx_lanes),
   .tx_sow        (tx_sow),
   .rx_sym        (rx_sym),
   .rx_code_err   (rx_code_err),
   .rx_word_valid (rx_word_valid)
);

// File: tb/tb_bal_link_gearbox.sv
module tb_bal_link_gearbox;
   localparam int G  = 6;
   localparam int GB = 32;
   localparam int WB = G * GB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid = 1'b0;
   logic [WB-1:0] tx_word = '0;
   logic          tx_ready;
   logic [6:0]    tx_lanes;
   logic          tx_sow;
   logic [6:0]    rx_lanes;
   logic          rx_sow;
   logic [5:0]    rx_sym;
   logic          rx_code_err;
   logic [WB-1:0] rx_word;
   logic          rx_word_valid;

   logic       ovr_l = 1'b0, ovr_s = 1'b0, ovr_sow = 1'b0;
   logic [6:0] ovr_lanes = 7'd0;
   assign rx_lanes = ovr_l ? ovr_lanes : tx_lanes;
   assign rx_sow   = ovr_s ? ovr_sow   : tx_sow;

   bal_link_gearbox dut (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_word(tx_word),
      .tx_ready(tx_ready), .tx_lanes(tx_lanes), .tx_sow(tx_sow),
      .rx_lanes(rx_lanes), .rx_sow(rx_sow), .rx_sym(rx_sym),
      .rx_code_err(rx_code_err), .rx_word(rx_word), .rx_word_valid(rx_word_valid)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0, bad_w = 0;
   bit reported = 1'b0;

   typedef struct { logic [WB-1:0] w; int due; } sb_t;
   sb_t sb_q[$];
   sb_t mon_it;

   task automatic chk(input bit ok, input string req, input string detail);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", req, detail);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   function automatic int ones(input logic [6:0] v);
      int n = 0;
      for (int b = 0; b < 7; b++) n += int'(v[b]);
      return n;
   endfunction

   function automatic bit bal(input logic [6:0] v);
      return ones(v) == 3 || ones(v) == 4;
   endfunction

   function automatic int rank(input logic [6:0] v);
      int n = 0;
      for (int u = 0; u < int'(v); u++) if (bal(7'(u))) n++;
      return n;
   endfunction

   function automatic logic [6:0] ref_enc(input logic [5:0] d);
      int n = 0;
      for (int u = 0; u < 128; u++) begin
         if (bal(7'(u))) begin
            if (n == int'(d)) return 7'(u);
            n++;
         end
      end
      return 7'd0;
   endfunction

   function automatic bit ref_ok(input logic [6:0] v);
      return bal(v) && rank(v) < 64;
   endfunction

   function automatic logic [5:0] sym_of(input logic [WB-1:0] w, input int k);
      logic [5:0] s;
      for (int i = 0; i < G; i++) s[i] = w[i*GB + k];
      return s;
   endfunction

   function automatic logic [WB-1:0] word_of_base(input int base);
      logic [WB-1:0] w = '0;
      for (int k = 0; k < GB; k++)
         for (int i = 0; i < G; i++) w[i*GB + k] = 1'((base + k) >> i);
      return w;
   endfunction

   // Scoreboard monitor: rebuilt words and their due cycle (R6, R7, R9).
   always @(negedge clk) begin
      if (rst_n) begin
         if (!bal(tx_lanes)) bad_w++;
         if (rx_word_valid) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R6", $sformatf("unexpected word actual %h expected none", rx_word));
            end else begin
               mon_it = sb_q.pop_front();
               chk(rx_word == mon_it.w, "R6/R7",
                   $sformatf("word actual %h expected %h", rx_word, mon_it.w));
               chk(cyc == mon_it.due, "R6/R9",
                   $sformatf("valid cycle actual %0d expected %0d", cyc, mon_it.due));
            end
         end
      end
   end

   task automatic send_word(input logic [WB-1:0] w, input bit watch, input int bad_k,
                            output int acc);
      sb_t it;
      bit inj = 1'b0;
      it.w = w;
      if (bad_k >= 0) for (int i = 0; i < G; i++) it.w[i*GB + bad_k] = 1'b0;
      tx_word  = w;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      acc    = cyc + 1;
      it.due = acc + 33;
      sb_q.push_back(it);
      @(negedge clk);
      tx_valid = 1'b0;
      if (watch || bad_k >= 0) begin
         chk(tx_ready == 1'b0, "R1", $sformatf("ready after take actual %b expected 0", tx_ready));
         for (int j = 0; j < 33; j++) begin
            @(negedge clk);
            if (inj) begin
               inj   = 1'b0;
               ovr_l = 1'b0;
               chk(rx_code_err == 1'b1 && rx_sym == 6'd0, "R5/R7",
                   $sformatf("err/sym actual %b/%h expected 1/00", rx_code_err, rx_sym));
            end
            if (watch && j < 32) begin
               chk(tx_lanes == ref_enc(sym_of(w, j)), "R2/R3",
                   $sformatf("lanes sym%0d actual %b expected %b", j, tx_lanes, ref_enc(sym_of(w, j))));
               chk(tx_sow == (j == 0), "R2",
                   $sformatf("sow sym%0d actual %b expected %b", j, tx_sow, j == 0));
            end
            if (j == bad_k) begin
               inj       = 1'b1;
               ovr_lanes = 7'b1111000;
               ovr_l     = 1'b1;
            end
         end
      end
   endtask

   task automatic rx_restart(input logic [WB-1:0] w);
      sb_t it;
      @(negedge clk);
      ovr_l = 1'b1; ovr_s = 1'b1; ovr_sow = 1'b1; ovr_lanes = ref_enc(6'd5);
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         ovr_sow = 1'b0; ovr_lanes = ref_enc(6'(j + 9));
      end
      @(negedge clk);
      it.w = w; it.due = cyc + 32;
      sb_q.push_back(it);
      for (int k = 0; k < GB; k++) begin
         ovr_sow = (k == 0); ovr_lanes = ref_enc(sym_of(w, k));
         @(negedge clk);
      end
      ovr_sow = 1'b0; ovr_l = 1'b0; ovr_s = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R6", "watchdog actual hung expected finish");
      report();
      $finish;
   end

   initial begin
      int a1, a2, a3;
      logic [WB-1:0] w2;
      repeat (4) @(negedge clk);
      chk(tx_ready == 1'b1 && tx_sow == 1'b0 && tx_lanes == 7'b0000111, "R10",
          $sformatf("in reset rdy/sow/lanes actual %b/%b/%b expected 1/0/0000111", tx_ready, tx_sow, tx_lanes));
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_word_valid == 1'b0 && rx_code_err == 1'b0 && rx_sym == 6'd0, "R10",
          $sformatf("rx valid/err/sym actual %b/%b/%h expected 0/0/00", rx_word_valid, rx_code_err, rx_sym));
      chk(tx_lanes == 7'b0000111 && tx_sow == 1'b0, "R4",
          $sformatf("idle lanes/sow actual %b/%b expected 0000111/0", tx_lanes, tx_sow));

      // Full decoder sweep (R5).
      ovr_l = 1'b1; ovr_s = 1'b1; ovr_sow = 1'b0;
      for (int v = 0; v < 128; v++) begin
         ovr_lanes = 7'(v);
         @(negedge clk);
         chk(rx_code_err == !ref_ok(7'(v)) && rx_sym == (ref_ok(7'(v)) ? 6'(rank(7'(v))) : 6'd0), "R5",
             $sformatf("pattern %b err/sym actual %b/%h expected %b/%h", 7'(v), rx_code_err, rx_sym,
                       !ref_ok(7'(v)), ref_ok(7'(v)) ? 6'(rank(7'(v))) : 6'd0));
      end
      ovr_l = 1'b0; ovr_s = 1'b0;
      repeat (2) @(negedge clk);

      // All 64 codes through the encoder, with lane timing (R1, R2, R3).
      send_word(word_of_base(0), 1'b1, -1, a1);
      send_word(word_of_base(32), 1'b1, -1, a1);
      repeat (3) @(negedge clk);
      chk(tx_lanes == 7'b0000111 && tx_sow == 1'b0 && tx_ready == 1'b1, "R4",
          $sformatf("post-word lanes/sow/rdy actual %b/%b/%b expected 0000111/0/1", tx_lanes, tx_sow, tx_ready));

      // Back-to-back words (R9).
      w2 = {32'h8000_0001, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, 32'hCAFE_F00D, 32'h5555_AAAA};
      send_word({WB{1'b1}}, 1'b0, -1, a1);
      send_word(w2, 1'b0, -1, a2);
      send_word(~w2, 1'b0, -1, a3);
      chk(a2 - a1 == 32 && a3 - a2 == 32, "R9",
          $sformatf("accept spacing actual %0d/%0d expected 32/32", a2 - a1, a3 - a2));
      repeat (40) @(negedge clk);

      // Corrupted symbols zero their bit column (R7).
      send_word(w2, 1'b0, 0, a1);
      send_word(~w2, 1'b0, 31, a1);
      send_word({WB{1'b1}}, 1'b0, 13, a1);
      repeat (4) @(negedge clk);

      // Strobe in mid-word restarts assembly (R8).
      rx_restart(w2);
      repeat (40) @(negedge clk);
      chk(sb_q.size() == 0, "R6/R8", $sformatf("pending words actual %0d expected 0", sb_q.size()));
      chk(bad_w == 0, "R3", $sformatf("unbalanced lane cycles actual %0d expected 0", bad_w));
      report();
      $finish;
   end
endmodule